// File: doc/BRIEF.md
# Tag Check Fault Reporter

This block decides what a processor does once a memory tag comparison has failed. One fault event arrives per cycle on a valid strobe. It carries the faulting virtual address, a store/load flag, whether the translation regime is unprivileged, which privileged level owns the regime, whether that regime splits the address space into two ranges, and the 64-bit system control value in force for that regime.

A 2-bit check-fail mode is read out of the control value. The mode selects one of four outcomes:
- ignore the fault;
- raise a synchronous data-abort pulse, with the address latched and a syndrome;
- set a sticky asynchronous flag in a per-level status register;
- split by direction: asynchronous for stores, synchronous for loads.

Software clears or rewrites the status registers through a dedicated write port. Exception vectoring and interrupt delivery are handled elsewhere.

Top module: `tag_fault_reporter`

## Requirements
- R1: After reset, `exc_pulse` is 0, `exc_addr` and `exc_syndrome` are 0, and every status register reads 0.
- R2: For an unprivileged regime (`fault_unpriv`=1) the mode is `ctrl_value[39:38]`. Otherwise it is `ctrl_value[41:40]`. The mode values are: 0 ignore, 1 synchronous, 2 asynchronous, 3 split.
- R3: In mode 0 a fault changes no output: no pulse, and no status bit changes.
- R4: In mode 1, `exc_pulse` is 1 in the cycle after the fault for exactly that cycle. In that cycle, `exc_addr` equals the fault address. `exc_syndrome[5:0]` is 0x11 and `exc_syndrome[6]` equals the write flag.
- R5: In mode 2, a fault sets an asynchronous flag and raises no pulse.
- R6: In mode 3, a store behaves as mode 2 and a load behaves as mode 1.
- R7: The flag set is bit `fault_addr[55]` of the level's 2-bit status field when `fault_two_ranges`=1, and bit 0 otherwise.
- R8: Status bits are sticky: a new flag is ORed in, and no fault clears a bit.
- R9: Unprivileged regimes update level 0. Privileged regimes update the level given by `fault_level`, which is ignored when `fault_unpriv`=1. Level n occupies `async_status[2n+1:2n]`.
- R10: A software write replaces the selected level's field, visible the next cycle. A fault to the same level in the same cycle is ORed on top of the written value.
- R11: `exc_addr` and `exc_syndrome` hold their values until the next synchronous exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_valid | input | 1 | A tag check failure is presented this cycle |
| fault_addr | input | 64 | Faulting virtual address |
| fault_write | input | 1 | 1 for a store, 0 for a load |
| fault_unpriv | input | 1 | Regime is unprivileged |
| fault_level | input | 2 | Privilege level owning a privileged regime |
| fault_two_ranges | input | 1 | Regime uses two address ranges |
| ctrl_value | input | 64 | System control value for the regime |
| sw_wr_en | input | 1 | Software status write strobe |
| sw_wr_level | input | 2 | Level whose status field is written |
| sw_wr_data | input | 2 | New status field value |
| exc_pulse | output | 1 | Synchronous exception, one-cycle pulse |
| exc_addr | output | 64 | Latched faulting address |
| exc_syndrome | output | 7 | [5:0] fault status 0x11, [6] write flag |
| async_status | output | 8 | Sticky flags, 2 bits per level |

## Verification
The bench varies the mode field and the privilege bit independently. A design that read one fixed bit pair would then ignore faults it should report, or report faults it should ignore. Mode 3 is driven with both directions, because a design that split the wrong way would raise exceptions on stores. Repeated faults and software writes that collide with a fault in the same cycle expose flags that are overwritten instead of ORed. Unprivileged faults carrying a nonzero level expose a design that files them under the wrong level.

// File: rtl/tag_fault_pkg.sv
package tag_fault_pkg;

    typedef enum logic [1:0] {
        CHK_IGNORE = 2'd0,
        CHK_SYNC   = 2'd1,
        CHK_ASYNC  = 2'd2,
        CHK_SPLIT  = 2'd3
    } chk_mode_e;

    localparam int          SYN_W   = 7;
    localparam logic [5:0]  FSC_TAG = 6'h11;

    typedef struct packed {
        logic       raise_sync;
        logic       set_async;
        logic [1:0] flag_mask;
    } fault_action_t;

endpackage

// File: rtl/tag_fault_decode.sv
module tag_fault_decode
    import tag_fault_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int CTRL_W     = 64,
    parameter int UNPRIV_LSB = 38,
    parameter int PRIV_LSB   = 40,
    parameter int SEL_BIT    = 55
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              unpriv,
    input  logic              two_ranges,
    input  logic [CTRL_W-1:0] ctrl,
    output chk_mode_e         mode,
    output fault_action_t     act
);

    logic sel_hi;
    logic unused_ok;

    assign unused_ok = ^{addr, ctrl};

    always_comb begin
        if (unpriv) begin
            mode = chk_mode_e'(ctrl[UNPRIV_LSB +: 2]);
        end else begin
            mode = chk_mode_e'(ctrl[PRIV_LSB +: 2]);
        end
    end

    always_comb begin
        sel_hi         = two_ranges & addr[SEL_BIT];
        act            = '0;
        act.flag_mask  = sel_hi ? 2'b10 : 2'b01;
        if (valid) begin
            unique case (mode)
                CHK_IGNORE: ;
                CHK_SYNC:   act.raise_sync = 1'b1;
                CHK_ASYNC:  act.set_async  = 1'b1;
                CHK_SPLIT: begin
                    act.raise_sync = ~write;
                    act.set_async  = write;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (valid && mode == CHK_IGNORE) begin
            AST_IGNORE_QUIET: assert (!act.raise_sync && !act.set_async); // R3
        end
        if (valid && act.raise_sync) begin
            AST_SYNC_ONLY_LOAD_OR_MODE1: assert (mode == CHK_SYNC || !write); // R6
        end
    end

endmodule

// File: rtl/tag_fault_sync.sv
module tag_fault_sync
    import tag_fault_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output logic              exc_pulse,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [SYN_W-1:0]  exc_syndrome
);

    typedef struct packed {
        logic              pulse;
        logic [ADDR_W-1:0] addr;
        logic [SYN_W-1:0]  syn;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = raise;
        if (raise) begin
            st_d.addr = addr;
            st_d.syn  = {write, FSC_TAG};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_pulse    = st_q.pulse;
    assign exc_addr     = st_q.addr;
    assign exc_syndrome = st_q.syn;

    AST_SYN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> exc_syndrome[5:0] == FSC_TAG); // R4

    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> (exc_addr == $past(addr) && exc_syndrome[6] == $past(write))); // R4

    AST_HOLD_INFO: assert property (@(posedge clk) disable iff (!rst_n)
        !raise |=> ($stable(exc_addr) && $stable(exc_syndrome))); // R11

endmodule

// File: rtl/tag_fault_status.sv
module tag_fault_status #(
    parameter int NUM_LVL = 4,
    parameter int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [LVL_W-1:0]     set_lvl,
    input  logic [1:0]           set_mask,
    input  logic                 sw_wr_en,
    input  logic [LVL_W-1:0]     sw_wr_lvl,
    input  logic [1:0]           sw_wr_data,
    output logic [2*NUM_LVL-1:0] status
);

    typedef struct packed {
        logic [NUM_LVL-1:0][1:0] flags;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (sw_wr_en && sw_wr_lvl == LVL_W'(i)) begin
                st_d.flags[i] = sw_wr_data;
            end
            if (set_en && set_lvl == LVL_W'(i)) begin
                st_d.flags[i] = st_d.flags[i] | set_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign status[2*g +: 2] = st_q.flags[g];

        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            !(sw_wr_en && sw_wr_lvl == LVL_W'(g)) |=>
                ((status[2*g +: 2] & $past(status[2*g +: 2])) == $past(status[2*g +: 2]))); // R8

        AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_wr_en && sw_wr_lvl == LVL_W'(g)) |=>
                ((status[2*g +: 2] & $past(sw_wr_data)) == $past(sw_wr_data))); // R10
    end

endmodule

// File: rtl/tag_fault_reporter.sv
module tag_fault_reporter
    import tag_fault_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int CTRL_W     = 64,
    parameter int NUM_LVL    = 4,
    parameter int UNPRIV_LSB = 38,
    parameter int PRIV_LSB   = 40,
    parameter int SEL_BIT    = 55,
    localparam int LVL_W     = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int STAT_W    = 2 * NUM_LVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic              fault_write,
    input  logic              fault_unpriv,
    input  logic [LVL_W-1:0]  fault_level,
    input  logic              fault_two_ranges,
    input  logic [CTRL_W-1:0] ctrl_value,
    input  logic              sw_wr_en,
    input  logic [LVL_W-1:0]  sw_wr_level,
    input  logic [1:0]        sw_wr_data,
    output logic              exc_pulse,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [SYN_W-1:0]  exc_syndrome,
    output logic [STAT_W-1:0] async_status
);

    chk_mode_e     mode;
    fault_action_t act;
    logic [LVL_W-1:0] target_lvl;

    assign target_lvl = fault_unpriv ? '0 : fault_level;

    tag_fault_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_W    (CTRL_W),
        .UNPRIV_LSB(UNPRIV_LSB),
        .PRIV_LSB  (PRIV_LSB),
        .SEL_BIT   (SEL_BIT)
    ) decode_i (
        .valid     (fault_valid),
        .addr      (fault_addr),
        .write     (fault_write),
        .unpriv    (fault_unpriv),
        .two_ranges(fault_two_ranges),
        .ctrl      (ctrl_value),
        .mode      (mode),
        .act       (act)
    );

    tag_fault_sync #(
        .ADDR_W(ADDR_W)
    ) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise       (act.raise_sync),
        .addr        (fault_addr),
        .write       (fault_write),
        .exc_pulse   (exc_pulse),
        .exc_addr    (exc_addr),
        .exc_syndrome(exc_syndrome)
    );

    tag_fault_status #(
        .NUM_LVL(NUM_LVL),
        .LVL_W  (LVL_W)
    ) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (act.set_async),
        .set_lvl   (target_lvl),
        .set_mask  (act.flag_mask),
        .sw_wr_en  (sw_wr_en),
        .sw_wr_lvl (sw_wr_level),
        .sw_wr_data(sw_wr_data),
        .status    (async_status)
    );

    AST_NO_IDLE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |=> !exc_pulse); // R4

    AST_ASYNC_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_unpriv && ctrl_value[PRIV_LSB +: 2] == 2'd2) |=> !exc_pulse); // R5

    AST_IGNORE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !sw_wr_en && fault_unpriv && ctrl_value[UNPRIV_LSB +: 2] == 2'd0)
            |=> (!exc_pulse && $stable(async_status))); // R3

    AST_SPLIT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_write && !fault_unpriv && ctrl_value[PRIV_LSB +: 2] == 2'd3)
            |=> !exc_pulse); // R6

endmodule

// File: tb/tag_fault_reporter_tb_top.sv
module tag_fault_reporter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [63:0] fault_addr = '0;
    logic        fault_write = 1'b0;
    logic        fault_unpriv = 1'b0;
    logic [1:0]  fault_level = '0;
    logic        fault_two_ranges = 1'b0;
    logic [63:0] ctrl_value = '0;
    logic        sw_wr_en = 1'b0;
    logic [1:0]  sw_wr_level = '0;
    logic [1:0]  sw_wr_data = '0;
    logic        exc_pulse;
    logic [63:0] exc_addr;
    logic [6:0]  exc_syndrome;
    logic [7:0]  async_status;

    int vectors = 0;
    int fails = 0;

    // reference state
    logic [1:0]  m_stat [4];
    logic        m_pulse;
    logic [63:0] m_addr;
    logic [6:0]  m_syn;

    always #5 clk = ~clk;

    tag_fault_reporter dut_i (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_write(fault_write),
        .fault_unpriv(fault_unpriv), .fault_level(fault_level),
        .fault_two_ranges(fault_two_ranges), .ctrl_value(ctrl_value),
        .sw_wr_en(sw_wr_en), .sw_wr_level(sw_wr_level), .sw_wr_data(sw_wr_data),
        .exc_pulse(exc_pulse), .exc_addr(exc_addr), .exc_syndrome(exc_syndrome),
        .async_status(async_status)
    );

    function automatic logic [7:0] packed_stat();
        return {m_stat[3], m_stat[2], m_stat[1], m_stat[0]};
    endfunction

    task automatic compare(input string req);
        vectors++;
        if (exc_pulse !== m_pulse || exc_addr !== m_addr ||
            exc_syndrome !== m_syn || async_status !== packed_stat()) begin
            fails++;
            $display("FAIL %s: actual pulse=%0b addr=%h syn=%h stat=%b expected pulse=%0b addr=%h syn=%h stat=%b",
                     req, exc_pulse, exc_addr, exc_syndrome, async_status,
                     m_pulse, m_addr, m_syn, packed_stat());
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare after the edge.
    task automatic step(input string req, input logic v, input logic [63:0] a,
                        input logic w, input logic up, input logic [1:0] lvl,
                        input logic tr, input logic [63:0] ctrl,
                        input logic swe, input logic [1:0] swl, input logic [1:0] swd);
        int mode;
        int idx;
        int bitsel;
        logic do_sync;
        logic do_async;
        fault_valid = v; fault_addr = a; fault_write = w; fault_unpriv = up;
        fault_level = lvl; fault_two_ranges = tr; ctrl_value = ctrl;
        sw_wr_en = swe; sw_wr_level = swl; sw_wr_data = swd;
        mode = up ? int'(ctrl[39:38]) : int'(ctrl[41:40]);
        do_sync  = v && (mode == 1 || (mode == 3 && !w));
        do_async = v && (mode == 2 || (mode == 3 && w));
        idx = up ? 0 : int'(lvl);
        bitsel = (tr && a[55]) ? 1 : 0;
        if (swe) m_stat[swl] = swd;
        if (do_async) m_stat[idx][bitsel] = 1'b1;
        m_pulse = do_sync;
        if (do_sync) begin
            m_addr = a;
            m_syn  = {w, 6'h11};
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic idle(input string req);
        step(req, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h0, 1'b0, 2'd0, 2'd0);
    endtask

    function automatic logic [63:0] mk_ctrl(input logic [1:0] unpriv_m, input logic [1:0] priv_m);
        logic [63:0] c;
        c = 64'hA5A5_0000_0000_5A5A;
        c[39:38] = unpriv_m;
        c[41:40] = priv_m;
        return c;
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_stat[i] = 2'b00;
        m_pulse = 1'b0; m_addr = '0; m_syn = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        idle("R1 idle after reset");

        // R2/R3: privileged uses [41:40]=0 though [39:38]=1
        step("R2 R3 priv ignore", 1'b1, 64'h0080_0000_0000_1000, 1'b0, 1'b0, 2'd1, 1'b1,
             mk_ctrl(2'd1, 2'd0), 1'b0, 2'd0, 2'd0);
        // R2/R4: unprivileged mode 1 from [39:38]
        step("R2 R4 unpriv sync load", 1'b1, 64'h0000_1234_5678_9AB0, 1'b0, 1'b1, 2'd0, 1'b0,
             mk_ctrl(2'd1, 2'd0), 1'b0, 2'd0, 2'd0);
        idle("R4 R11 pulse drops, info held");
        step("R4 sync store syndrome", 1'b1, 64'hFFFF_0000_0000_0040, 1'b1, 1'b0, 2'd2, 1'b1,
             mk_ctrl(2'd0, 2'd1), 1'b0, 2'd0, 2'd0);
        idle("R11 hold");
        // R3 unpriv mode 0
        step("R3 unpriv ignore", 1'b1, 64'h1, 1'b1, 1'b1, 2'd0, 1'b1,
             mk_ctrl(2'd0, 2'd2), 1'b0, 2'd0, 2'd0);
        // R5/R7: two ranges, addr55=1 -> bit1 of level0
        step("R5 R7 async two ranges", 1'b1, 64'h0080_0000_0000_0000, 1'b0, 1'b1, 2'd3, 1'b1,
             mk_ctrl(2'd2, 2'd0), 1'b0, 2'd0, 2'd0);
        // R7/R9: one range, addr55=1 ignored -> bit0 of level2
        step("R7 R9 async one range lvl2", 1'b1, 64'h0080_0000_0000_0000, 1'b0, 1'b0, 2'd2, 1'b0,
             mk_ctrl(2'd0, 2'd2), 1'b0, 2'd0, 2'd0);
        // R8 sticky repeat and OR
        step("R8 sticky repeat", 1'b1, 64'h10, 1'b0, 1'b0, 2'd2, 1'b0,
             mk_ctrl(2'd0, 2'd2), 1'b0, 2'd0, 2'd0);
        step("R8 OR second bit", 1'b1, 64'h0080_0000_0000_0010, 1'b1, 1'b0, 2'd2, 1'b1,
             mk_ctrl(2'd0, 2'd2), 1'b0, 2'd0, 2'd0);
        // R6 split
        step("R6 split store async", 1'b1, 64'h20, 1'b1, 1'b0, 2'd1, 1'b0,
             mk_ctrl(2'd0, 2'd3), 1'b0, 2'd0, 2'd0);
        step("R6 split load sync", 1'b1, 64'h0000_0000_0000_0F30, 1'b0, 1'b0, 2'd1, 1'b0,
             mk_ctrl(2'd0, 2'd3), 1'b0, 2'd0, 2'd0);
        step("R6 split unpriv load", 1'b1, 64'h0000_0000_0000_0F50, 1'b0, 1'b1, 2'd1, 1'b0,
             mk_ctrl(2'd3, 2'd0), 1'b0, 2'd0, 2'd0);
        // R10 software write clears, and collision OR
        step("R10 sw clear lvl2", 1'b0, 64'h0, 1'b0, 1'b0, 2'd0, 1'b0,
             64'h0, 1'b1, 2'd2, 2'd0);
        step("R10 sw write with fault", 1'b1, 64'h0080_0000_0000_0000, 1'b1, 1'b0, 2'd1, 1'b1,
             mk_ctrl(2'd0, 2'd2), 1'b1, 2'd1, 2'd0);
        // R9 unpriv ignores fault_level
        step("R9 unpriv to level0", 1'b1, 64'h40, 1'b1, 1'b1, 2'd3, 1'b0,
             mk_ctrl(2'd2, 2'd0), 1'b0, 2'd0, 2'd0);
        step("R10 sw clear lvl0", 1'b0, 64'h0, 1'b0, 1'b0, 2'd0, 1'b0,
             64'h0, 1'b1, 2'd0, 2'd0);
        // back-to-back sync
        step("R4 back to back a", 1'b1, 64'hAAAA, 1'b0, 1'b0, 2'd3, 1'b0,
             mk_ctrl(2'd0, 2'd1), 1'b0, 2'd0, 2'd0);
        step("R4 back to back b", 1'b1, 64'hBBBB, 1'b1, 1'b0, 2'd3, 1'b0,
             mk_ctrl(2'd0, 2'd1), 1'b0, 2'd0, 2'd0);
        idle("R11 final hold");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule